// File: doc/BRIEF.md
# Pin Interrupt and Wake Event Detector

This block sits behind a pin's input filter, one lane per pin. Each lane holds a small configuration word and watches the already-filtered pin level. It compares that level with the level it saw one cycle earlier, or looks at the level alone, depending on the programmed trigger type. When a trigger occurs, it latches an interrupt status bit and, depending on the current sleep state, a wake status bit. Both status bits are sticky and are cleared by writing one to them. Each lane drives a pending flag toward a system-level aggregator and a forwarded interrupt line that a per-pin mask bit gates.

Software reaches every lane through one 32-bit word per pin, selected by a word address. A global status-block input stands for a settling window after a configuration change. While it is high, no lane latches any status, and each lane's interrupt-enable bit reads back as 0. The stored enable value is kept and is visible again once the window closes.

Top module: `pin_evt_top`

## Requirements
- R1: After reset every configuration and status bit is 0, every word reads as 0 except the live level in bit 10, and all `pending` and `irqOut` bits are low.
- R2: In edge mode (bit 0 = 0), polarity 00 latches interrupt status (bit 8) on a 0-to-1 change of the pin level and polarity 01 on a 1-to-0 change. A level held steady latches nothing. Status is visible the cycle after the edge is sampled.
- R3: Polarity 10 latches on either edge in edge mode and never latches in level mode. Polarity 11 never latches in either mode.
- R4: In level mode (bit 0 = 1), polarity 00 latches while the pin is 1 and polarity 01 latches while it is 0. A clear issued while the level is still active has no lasting effect, because the status latches again in the same cycle. A clear sticks once the level is inactive.
- R5: Interrupt status latches only when the enable bit (bit 3) is 1. `irqOut` is interrupt status ANDed with the mask bit (bit 4). The mask does not affect status or `pending`.
- R6: Writing 1 to bit 8 clears interrupt status and writing 1 to bit 9 clears wake status. A write with those bits at 0 leaves status unchanged. A configuration write never sets status by itself.
- R7: Wake status (bit 9) latches on a trigger when the wake-enable bit for the current `sleepState` is 1. The enables are bit 5 for state 1 (light sleep), bit 6 for state 2 (suspend) and bit 7 for state 3 (off). State 0 (awake) never latches wake status. Wake latching does not depend on bit 3.
- R8: `pending` of a lane is the OR of its interrupt and wake status bits.
- R9: While `statusBlock` is 1, no status of any lane latches, and bit 3 reads 0 while the stored enable is kept. Edges that occur inside the window are lost.
- R10: A read returns `{21'b0, level, wakeSt, intSt, wakeEn[2:0], mask, enable, pol[1:0], levelMode}` (MSB first). Bits written to positions 10 and above are ignored. An address at or above `NUM_PINS` reads as 0, and a write to it changes no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Word (pin) address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed word (combinational) |
| pinLevel | input | NUM_PINS | Filtered level per pin |
| sleepState | input | 2 | 0 awake, 1 light sleep, 2 suspend, 3 off |
| statusBlock | input | 1 | Global window that suspends status generation |
| pending | output | NUM_PINS | Per-pin interrupt-or-wake status |
| irqOut | output | NUM_PINS | Per-pin masked interrupt |

## Verification
The bench builds the block with six lanes and a 3-bit address. This leaves two addresses past the last lane, so both the ignored-write path and the zero-read path are exercised. Every mode and polarity pair is swept against both edge directions and both held levels, and the cases are spread over all six lanes. All four sleep states are crossed with all eight wake-enable patterns. The expected status of each case is derived from the polarity, level and sleep encodings.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  localparam int DATA_W      = 32;
  localparam int CFG_W       = 8;
  localparam int BIT_INTST   = 8;
  localparam int BIT_WAKEST  = 9;
  localparam int BIT_LEVEL   = 10;
  localparam int USED_W      = BIT_LEVEL + 1;

  typedef enum logic [1:0] {
    POL_HIGH = 2'd0,
    POL_LOW  = 2'd1,
    POL_BOTH = 2'd2,
    POL_NONE = 2'd3
  } pol_e;

  typedef enum logic [1:0] {
    SLP_AWAKE   = 2'd0,
    SLP_LIGHT   = 2'd1,
    SLP_SUSPEND = 2'd2,
    SLP_OFF     = 2'd3
  } sleep_e;

  // Layout matches bits [7:0] of the register word
  typedef struct packed {
    logic [2:0] wakeEn;
    logic       intMask;
    logic       intEn;
    pol_e       pol;
    logic       levelMode;
  } pin_cfg_t;

  typedef struct packed {
    logic cfgWr;
    logic clrInt;
    logic clrWake;
  } lane_strobe_t;

endpackage

// File: rtl/pin_evt_trigger.sv
module pin_evt_trigger
  import pin_evt_pkg::*;
(
  input  logic levelMode,
  input  pol_e pol,
  input  logic curLevel,
  input  logic prevLevel,
  output logic hit
);

  logic rise;
  logic fall;

  assign rise = curLevel & ~prevLevel;
  assign fall = ~curLevel & prevLevel;

  always_comb begin
    unique case (pol)
      POL_HIGH: hit = levelMode ? curLevel  : rise;
      POL_LOW:  hit = levelMode ? ~curLevel : fall;
      POL_BOTH: hit = levelMode ? 1'b0      : (rise | fall);
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pin_evt_lane.sv
module pin_evt_lane
  import pin_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  lane_strobe_t       strobe,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic               pinLevel,
  input  sleep_e             sleepState,
  input  logic               statusBlock,
  output logic [DATA_W-1:0]  word,
  output logic               pending,
  output logic               irq
);

  pin_cfg_t cfg;
  logic     prevLevel;
  logic     intSt;
  logic     wakeSt;
  logic     hit;
  logic     armed;
  logic     wakeSel;
  logic     setInt;
  logic     setWake;

  pin_evt_trigger trig_i (
    .levelMode (cfg.levelMode),
    .pol       (cfg.pol),
    .curLevel  (pinLevel),
    .prevLevel (prevLevel),
    .hit       (hit)
  );

  always_comb begin
    unique case (sleepState)
      SLP_LIGHT:   wakeSel = cfg.wakeEn[0];
      SLP_SUSPEND: wakeSel = cfg.wakeEn[1];
      SLP_OFF:     wakeSel = cfg.wakeEn[2];
      default:     wakeSel = 1'b0;
    endcase
  end

  assign armed   = ~statusBlock;
  assign setInt  = hit & cfg.intEn & armed;
  assign setWake = hit & wakeSel & armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg       <= '0;
      prevLevel <= 1'b0;
      intSt     <= 1'b0;
      wakeSt    <= 1'b0;
    end else begin
      prevLevel <= pinLevel;
      if (strobe.cfgWr) cfg <= pin_cfg_t'(cfgData);
      // a new trigger in the clearing cycle wins over the clear
      intSt  <= setInt  | (intSt  & ~strobe.clrInt);
      wakeSt <= setWake | (wakeSt & ~strobe.clrWake);
    end
  end

  assign word = {{(DATA_W-USED_W){1'b0}}, pinLevel, wakeSt, intSt,
                 cfg.wakeEn, cfg.intMask, cfg.intEn & armed,
                 cfg.pol, cfg.levelMode};
  assign pending = intSt | wakeSt;
  assign irq     = intSt & cfg.intMask;

  AST_BLOCK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (statusBlock && !intSt && !wakeSt) |=> (!intSt && !wakeSt)); // R9

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.intEn && !intSt) |=> !intSt); // R5

  AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !cfg.levelMode && $stable(pinLevel) && !intSt) |=> !intSt); // R2

  AST_AWAKE_NO_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (sleepState == SLP_AWAKE && !wakeSt) |=> !wakeSt); // R7

endmodule

// File: rtl/pin_evt_ctrl.sv
module pin_evt_ctrl
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int ADDR_W   = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [NUM_PINS-1:0][DATA_W-1:0]   laneWord,
  output lane_strobe_t [NUM_PINS-1:0]       strobes,
  output logic [CFG_W-1:0]                  cfgData,
  output logic [DATA_W-1:0]                 rdData
);

  logic                unusedWrHi;
  logic [NUM_PINS-1:0] cfgWrVec;

  assign cfgData    = wrData[CFG_W-1:0];
  assign unusedWrHi = ^wrData[DATA_W-1:BIT_WAKEST+1];

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_dec
    logic sel;
    assign sel                = wrEn && (addr == ADDR_W'(g));
    assign strobes[g].cfgWr   = sel;
    assign strobes[g].clrInt  = sel & wrData[BIT_INTST];
    assign strobes[g].clrWake = sel & wrData[BIT_WAKEST];
    assign cfgWrVec[g]        = strobes[g].cfgWr;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (addr == ADDR_W'(i)) rdData = laneWord[i];
    end
  end

  AST_ONE_LANE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cfgWrVec)); // R10

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (cfgWrVec == '0)); // R10

endmodule

// File: rtl/pin_evt_top.sv
module pin_evt_top
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [1:0]          sleepState,
  input  logic                statusBlock,
  output logic [NUM_PINS-1:0] pending,
  output logic [NUM_PINS-1:0] irqOut
);

  lane_strobe_t [NUM_PINS-1:0]     strobes;
  logic [NUM_PINS-1:0][DATA_W-1:0] laneWord;
  logic [CFG_W-1:0]                cfgData;
  sleep_e                          sleepSt;

  assign sleepSt = sleep_e'(sleepState);

  pin_evt_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .laneWord (laneWord),
    .strobes  (strobes),
    .cfgData  (cfgData),
    .rdData   (rdData)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_lane
    pin_evt_lane lane_i (
      .clk         (clk),
      .rstN        (rstN),
      .strobe      (strobes[g]),
      .cfgData     (cfgData),
      .pinLevel    (pinLevel[g]),
      .sleepState  (sleepSt),
      .statusBlock (statusBlock),
      .word        (laneWord[g]),
      .pending     (pending[g]),
      .irq         (irqOut[g])
    );
  end

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~pending) == '0); // R8

endmodule

// File: tb/pin_evt_top_tb.sv
module pin_evt_top_tb_top;

  localparam int  NP       = 6;
  localparam int  AW       = 3;
  localparam time CLK_PER  = 10ns;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NP-1:0] pinLevel = '0;
  logic [1:0]    sleepState = 2'd0;
  logic          statusBlock = 1'b0;
  logic [NP-1:0] pending;
  logic [NP-1:0] irqOut;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PER/2) clk = ~clk;

  pin_evt_top #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinLevel(pinLevel), .sleepState(sleepState),
    .statusBlock(statusBlock), .pending(pending), .irqOut(irqOut)
  );

  localparam logic [31:0] CLR   = 32'h300;
  localparam logic [31:0] EN    = 32'h8;
  localparam logic [31:0] MSK   = 32'h10;
  localparam logic [31:0] LVL   = 32'h1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    addr = AW'(a);
    #1;
    v = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int idx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();

    // R1 reset state
    for (int a = 0; a < (1 << AW); a++) begin
      rd(a, v);
      check("R1 reset word", v, 32'h0);
    end
    check("R1 reset pending", 32'(pending), 32'h0);
    check("R1 reset irqOut", 32'(irqOut), 32'h0);

    // R2/R3/R8 edge-mode sweep
    idx = 0;
    for (int pol = 0; pol < 4; pol++) begin
      for (int st = 0; st < 2; st++) begin
        int p;
        logic expHit;
        p = idx % NP; idx++;
        pinLevel[p] = st[0];
        step(); step();
        wr(p, CLR);
        wr(p, CLR | EN | MSK | 32'(pol << 1));
        step();
        rd(p, v);
        check("R2 steady edge level no status", 32'(v[8]), 32'h0);
        pinLevel[p] = ~st[0];
        step();
        expHit = (pol == 0 && st == 0) || (pol == 1 && st == 1) || (pol == 2);
        rd(p, v);
        check(pol >= 2 ? "R3 edge both/none status" : "R2 edge status",
              32'(v[8]), 32'(expHit));
        check("R8 pending follows status", 32'(pending[p]), 32'(expHit));
        check("R5 irq with mask set", 32'(irqOut[p]), 32'(expHit));
        wr(p, CLR);
      end
    end

    // R4/R3 level-mode sweep
    for (int pol = 0; pol < 4; pol++) begin
      for (int lv = 0; lv < 2; lv++) begin
        int p;
        logic expHit;
        p = idx % NP; idx++;
        pinLevel[p] = lv[0];
        step();
        wr(p, CLR);
        wr(p, CLR | EN | MSK | LVL | 32'(pol << 1));
        step();
        expHit = (pol == 0 && lv == 1) || (pol == 1 && lv == 0);
        rd(p, v);
        check(pol >= 2 ? "R3 level both/none no status" : "R4 level status",
              32'(v[8]), 32'(expHit));
        wr(p, CLR);
      end
    end

    // R4 re-latch after clear while active
    pinLevel[1] = 1'b1;
    step();
    wr(1, CLR | EN | LVL);
    step();
    wr(1, 32'h100 | EN | LVL);
    rd(1, v);
    check("R4 relatch while active", 32'(v[8]), 32'h1);
    pinLevel[1] = 1'b0;
    wr(1, 32'h100 | EN | LVL);
    step();
    rd(1, v);
    check("R4 clear sticks when inactive", 32'(v[8]), 32'h0);
    wr(1, CLR);

    // R5 enable gate and mask
    pinLevel[2] = 1'b0;
    wr(2, CLR | MSK);
    pinLevel[2] = 1'b1;
    step();
    rd(2, v);
    check("R5 disabled no status", 32'(v[8]), 32'h0);
    check("R5 disabled no irq", 32'(irqOut[2]), 32'h0);
    pinLevel[2] = 1'b0;
    wr(2, CLR | EN);
    pinLevel[2] = 1'b1;
    step();
    rd(2, v);
    check("R5 masked status set", 32'(v[8]), 32'h1);
    check("R5 masked pending set", 32'(pending[2]), 32'h1);
    check("R5 masked irq low", 32'(irqOut[2]), 32'h0);
    wr(2, EN | MSK);
    rd(2, v);
    check("R6 write without clear keeps status", 32'(v[8]), 32'h1);
    check("R5 unmasked irq", 32'(irqOut[2]), 32'h1);
    wr(2, 32'h100 | EN | MSK);
    rd(2, v);
    check("R6 w1c clears status", 32'(v[8]), 32'h0);
    check("R6 irq drops after clear", 32'(irqOut[2]), 32'h0);

    // R7 wake sweep
    for (int s = 0; s < 4; s++) begin
      for (int we = 0; we < 8; we++) begin
        logic expW;
        pinLevel[3] = 1'b0;
        sleepState = 2'(s);
        wr(3, CLR);
        wr(3, CLR | 32'(we << 5));
        pinLevel[3] = 1'b1;
        step();
        expW = (s != 0) && we[s - 1];
        rd(3, v);
        check("R7 wake status", 32'(v[9]), 32'(expW));
        check("R7 no int status without enable", 32'(v[8]), 32'h0);
        check("R8 pending from wake", 32'(pending[3]), 32'(expW));
      end
    end
    wr(3, 32'h200);
    rd(3, v);
    check("R6 wake w1c", 32'(v[9]), 32'h0);
    sleepState = 2'd0;
    wr(3, CLR);

    // R9 block window
    pinLevel[4] = 1'b0;
    wr(4, CLR | EN | MSK);
    statusBlock = 1'b1;
    rd(4, v);
    check("R9 enable reads 0 in window", 32'(v[3]), 32'h0);
    pinLevel[4] = 1'b1;
    step();
    rd(4, v);
    check("R9 no status in window", 32'(v[8]), 32'h0);
    statusBlock = 1'b0;
    step();
    rd(4, v);
    check("R9 enable restored", 32'(v[3]), 32'h1);
    check("R9 edge in window lost", 32'(v[8]), 32'h0);

    // R10 layout and address range
    pinLevel[5] = 1'b1;
    wr(5, 32'hFFFF_FFFF);
    rd(5, v);
    check("R10 readback layout", v, 32'h0000_04FF);
    wr(6, 32'hFFFF_FFFF);
    rd(6, v);
    check("R10 out of range read", v, 32'h0);
    rd(7, v);
    check("R10 top address read", v, 32'h0);
    rd(5, v);
    check("R10 lane 5 unchanged", v, 32'h0000_04FF);
    rd(0, v);
    check("R10 lane 0 unchanged", v, 32'(pinLevel[0]) << 10);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule